// File: doc/BRIEF.md
# I2C Master START Generator with Stuck-Line Recovery

This block opens an I2C transaction on behalf of a master. While a start request flag is held high, it watches both bus lines through a synchroniser. It decides whether the bus is free and then drives a START condition through open-drain enables. SDA is pulled low while SCL is left high for one half-period. After that SCL is pulled low too, and the block holds the bus in that state. Success shows as status code 08H together with a raised interrupt flag. At all other times the status code reads F8H.

Another device may be holding SDA low while the bus looks idle. In that case the block does not issue a START. It toggles SCL to walk the stuck device out of its bit. After each pair of these pulses it checks SDA again, and it issues the START once SDA reads high. No software acts between attempts. The block waits when SCL is held low by someone else, because it cannot resolve that case. When the bus stays busy for too long, the block gives up waiting and takes the bus. Dropping the request releases SCL first and SDA half a period later, which leaves a STOP on the bus.

Top module: `i2c_start_gen`

## Requirements
- R1: After reset both line enables are 0 (lines released), the status code is F8H and the interrupt flag is 0.
- R2: With a request on a free bus and both lines high, SDA is driven low first. SCL follows exactly HALF_CYC cycles later. At that moment the status becomes 08H and the interrupt flag rises, and the bus stays held until the request drops.
- R3: When SDA reads low at a START attempt with SCL high, SDA is not driven. SCL is pulsed instead: driven low for HALF_CYC cycles, then released for HALF_CYC cycles. The status stays F8H and the interrupt flag stays 0 throughout.
- R4: A new START attempt follows every second recovery pulse, so a START that follows recovery is always preceded by an even, non-zero number of pulses. These are the smallest pair count that ends after SDA was released.
- R5: While SCL reads low at an attempt, neither line is driven and the block keeps waiting. Once SCL is released, it proceeds as in R2.
- R6: A START seen on the bus (SDA falling while SCL high) marks it busy, and a STOP (SDA rising while SCL high) marks it free. A request on a busy bus drives nothing until a STOP arrives. If no STOP arrives, the block forces an attempt after BUSY_LIMIT cycles.
- R7: A forced attempt that finds SDA low runs the same pulse recovery as R3 and R4.
- R8: When the request drops while the bus is held, SCL is released first and SDA exactly HALF_CYC cycles later, and the interrupt flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Start request flag; held high until the transaction ends |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| status | output | 8 | 08H after a START is on the bus, F8H otherwise |
| irq | output | 1 | Raised on a successful START, cleared when the request drops |

## Verification
The START path is tried under five line patterns:
- a clean free bus;
- SDA stuck low on a free bus, released during the third pulse;
- SCL held low by another device;
- a bus made busy by a foreign START and freed by a foreign STOP;
- a busy bus with SDA still low that is never freed.

The pulse count recorded before each START separates a plain START (zero pulses) from recovery that respects the pair cadence (four pulses, not three). The waiting cases show the block holding off without driving, and the forced case shows the timeout leading into recovery. Edge spacing between SDA and SCL is measured on both the START and the release.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_BUSY,
        ST_ATTEMPT,
        ST_START_SDA,
        ST_HOLD,
        ST_PULSE_LO,
        ST_PULSE_HI,
        ST_STOP_REL
    } gen_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_pair_t;

    localparam logic [7:0] STAT_START_SENT = 8'h08;
    localparam logic [7:0] STAT_NO_INFO    = 8'hF8;

    function automatic logic [7:0] status_of(gen_state_e s);
        return (s == ST_HOLD) ? STAT_START_SENT : STAT_NO_INFO;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_start_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  line_pair_t raw,
    output line_pair_t synced
);

    line_pair_t chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '1;
        end else begin
            chain[0] <= raw;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign synced = chain[STAGES-1];

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
    import i2c_start_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_pair_t now,
    output logic       busy
);

    line_pair_t prev;
    logic start_seen, stop_seen;

    assign start_seen = prev.scl && now.scl && prev.sda && !now.sda;
    assign stop_seen  = prev.scl && now.scl && !prev.sda && now.sda;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '1;
            busy <= 1'b0;
        end else begin
            prev <= now;
            if (start_seen)     busy <= 1'b1;
            else if (stop_seen) busy <= 1'b0;
        end
    end

    // R6: a STOP on the bus always leaves it free on the following cycle
    a_r6_stop_frees: assert property (@(posedge clk) disable iff (rst)
        (prev.scl && now.scl && !prev.sda && now.sda) |=> !busy);

endmodule

// File: rtl/i2c_start_fsm.sv
module i2c_start_fsm
    import i2c_start_pkg::*;
#(
    parameter int HALF_CYC   = 250,
    parameter int BUSY_LIMIT = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_req,
    input  line_pair_t line,
    input  logic       busy,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic [7:0] status,
    output logic       irq
);

    localparam int HW = $clog2(HALF_CYC + 1);
    localparam int TW = $clog2(BUSY_LIMIT + 1);

    gen_state_e    state, nxt;
    logic [HW-1:0] half_cnt;
    logic [TW-1:0] busy_cnt;
    logic          pulse_odd;
    logic          half_done;

    assign half_done = (half_cnt == HW'(HALF_CYC - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (start_req) nxt = busy ? ST_WAIT_BUSY : ST_ATTEMPT;
            ST_WAIT_BUSY: if (!start_req) nxt = ST_IDLE;
                          else if (!busy || busy_cnt == TW'(BUSY_LIMIT - 1)) nxt = ST_ATTEMPT;
            ST_ATTEMPT:   if (!start_req) nxt = ST_IDLE;
                          else if (line.scl) nxt = line.sda ? ST_START_SDA : ST_PULSE_LO;
            ST_START_SDA: if (half_done) nxt = ST_HOLD;
            ST_HOLD:      if (!start_req) nxt = ST_STOP_REL;
            ST_PULSE_LO:  if (half_done) nxt = ST_PULSE_HI;
            ST_PULSE_HI:  if (half_done) nxt = pulse_odd ? ST_ATTEMPT : ST_PULSE_LO;
            ST_STOP_REL:  if (half_done) nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            half_cnt  <= '0;
            busy_cnt  <= '0;
            pulse_odd <= 1'b0;
            irq       <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt != state)    half_cnt <= '0;
            else if (!half_done) half_cnt <= half_cnt + 1'b1;
            if (state == ST_WAIT_BUSY && nxt == ST_WAIT_BUSY) busy_cnt <= busy_cnt + 1'b1;
            else                                               busy_cnt <= '0;
            if (state == ST_ATTEMPT)                    pulse_odd <= 1'b0;
            else if (state == ST_PULSE_HI && half_done) pulse_odd <= ~pulse_odd;
            if (nxt == ST_HOLD && state != ST_HOLD)     irq <= 1'b1;
            else if (state == ST_HOLD && !start_req)    irq <= 1'b0;
        end
    end

    assign scl_oe = (state == ST_HOLD) || (state == ST_PULSE_LO);
    assign sda_oe = (state == ST_START_SDA) || (state == ST_HOLD) || (state == ST_STOP_REL);
    assign status = status_of(state);

    a_r1_irq_with_code: assert property (@(posedge clk) disable iff (rst)
        irq |-> status == STAT_START_SENT);

    a_r2_hold_after_sda: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && $past(state) != ST_HOLD) |-> $past(state) == ST_START_SDA);

    a_r3_pulse_needs_low_sda: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PULSE_LO && $past(state) == ST_ATTEMPT) |-> !$past(line.sda));

    a_r4_pairs_before_retry: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ATTEMPT && $past(state) == ST_PULSE_HI) |-> $past(pulse_odd));

    a_r5_wait_on_low_scl: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ATTEMPT && !line.scl && start_req) |=> state == ST_ATTEMPT);

    a_r6_busy_window: assert property (@(posedge clk) disable iff (rst)
        busy_cnt < TW'(BUSY_LIMIT));

    initial a_r3_half_len: assert (HALF_CYC >= 3);

endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
    import i2c_start_pkg::*;
#(
    parameter int HALF_CYC    = 250,
    parameter int BUSY_LIMIT  = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_req,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic [7:0] status,
    output logic       irq
);

    line_pair_t raw_lines, sync_lines;
    logic       bus_busy;

    assign raw_lines = '{scl: scl_in, sda: sda_in};

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (raw_lines),
        .synced (sync_lines)
    );

    i2c_bus_monitor u_mon (
        .clk  (clk),
        .rst  (rst),
        .now  (sync_lines),
        .busy (bus_busy)
    );

    i2c_start_fsm #(.HALF_CYC(HALF_CYC), .BUSY_LIMIT(BUSY_LIMIT)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .line      (sync_lines),
        .busy      (bus_busy),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .status    (status),
        .irq       (irq)
    );

endmodule

// File: tb/test_i2c_start_gen.sv
`timescale 1ns/1ps
module test_i2c_start_gen;

    localparam int HALF  = 4;
    localparam int LIMIT = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 1'b0;
    logic ext_scl_low = 1'b0;
    logic ext_sda_low = 1'b0;
    logic scl_oe, sda_oe, irq;
    logic [7:0] status;
    logic scl_in, sda_in;

    int vectors = 0;
    int miscompares = 0;
    int cycle = 0;
    int pulses = 0;
    int exp_q[$];
    logic prev_scl_oe = 1'b0;
    logic prev_irq = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_in = !(scl_oe || ext_scl_low);
    assign sda_in = !(sda_oe || ext_sda_low);

    i2c_start_gen #(.HALF_CYC(HALF), .BUSY_LIMIT(LIMIT)) i_i2c_start_gen (
        .clk(clk), .rst(rst), .start_req(start_req),
        .scl_in(scl_in), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .status(status), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // monitor: counts recovery pulses, checks line rules, pops expectations on irq
    always @(negedge clk) begin
        cycle++;
        if (!rst) begin
            if (scl_oe && !prev_scl_oe && status == 8'hF8) pulses++;
            if (scl_oe && status == 8'hF8 && sda_oe)
                chk(1'b0, "R3 sda driven during pulse", 1, 0);
            if (irq && !prev_irq) begin
                if (exp_q.size() == 0) chk(1'b0, "R4 unexpected start", pulses, -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(pulses == e, "R4 pulse count before start", pulses, e);
                end
                chk(scl_oe && sda_oe && status == 8'h08, "R2 held bus with code 08H",
                    int'(status), 8);
            end
        end
        prev_scl_oe = scl_oe;
        prev_irq = irq;
        if (cycle > 100000) begin
            chk(1'b0, "watchdog", cycle, 100000);
            finish_run();
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic request(input int exp_pulses);
        exp_q.push_back(exp_pulses);
        pulses = 0;
        start_req = 1'b1;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 500) begin @(negedge clk); n++; end
        chk(irq, req, int'(irq), 1);
    endtask

    task automatic release_bus();
        int t0, t1;
        start_req = 1'b0;
        while (scl_oe) @(negedge clk);
        t0 = cycle;
        chk(sda_oe, "R8 SDA still low after SCL release", int'(sda_oe), 1);
        chk(!irq, "R8 irq cleared", int'(irq), 0);
        while (sda_oe) @(negedge clk);
        t1 = cycle;
        chk(t1 - t0 == HALF, "R8 SCL-to-SDA release spacing", t1 - t0, HALF);
        cycles(8);
    endtask

    initial begin
        int t_sda, t_scl, t_req;
        cycles(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!scl_oe && !sda_oe, "R1 lines released", int'({scl_oe, sda_oe}), 0);
        chk(status == 8'hF8, "R1 status F8H", int'(status), 248);
        chk(!irq, "R1 irq low", int'(irq), 0);

        // R2 clean START on a free bus
        request(0);
        while (!sda_oe) @(negedge clk);
        t_sda = cycle;
        chk(!scl_oe, "R2 SCL high while SDA falls", int'(scl_oe), 0);
        while (!scl_oe) @(negedge clk);
        t_scl = cycle;
        chk(t_scl - t_sda == HALF, "R2 SDA-to-SCL spacing", t_scl - t_sda, HALF);
        wait_irq("R2 irq raised");
        cycles(5);
        chk(scl_oe && sda_oe && irq, "R2 bus held while requested", int'({scl_oe, sda_oe}), 3);
        release_bus();

        // R3/R4 SDA stuck on a free bus (set under SCL low: no START on the bus)
        ext_scl_low = 1'b1; cycles(2);
        ext_sda_low = 1'b1; cycles(2);
        ext_scl_low = 1'b0; cycles(6);
        request(4);
        cycles(2);
        chk(!sda_oe && status == 8'hF8, "R3 no START while SDA low", int'(sda_oe), 0);
        while (pulses < 3) @(negedge clk);
        chk(!irq, "R3 irq low during recovery", int'(irq), 0);
        ext_sda_low = 1'b0;
        wait_irq("R4 START after pulse pair");
        release_bus();

        // R5 SCL held low by another device
        ext_scl_low = 1'b1; cycles(2);
        request(0);
        cycles(30);
        chk(!scl_oe && !sda_oe, "R5 no drive while SCL low", int'({scl_oe, sda_oe}), 0);
        chk(!irq, "R5 no irq while SCL low", int'(irq), 0);
        ext_scl_low = 1'b0;
        wait_irq("R5 START after SCL release");
        release_bus();

        // R6 busy bus freed by a foreign STOP
        ext_sda_low = 1'b1; cycles(6);
        request(0);
        cycles(20);
        chk(!scl_oe && !sda_oe, "R6 no drive on busy bus", int'({scl_oe, sda_oe}), 0);
        ext_sda_low = 1'b0;
        wait_irq("R6 START after STOP");
        release_bus();

        // R6/R7 bus busy past the limit with SDA still low
        ext_sda_low = 1'b1; cycles(6);
        t_req = cycle + 1;
        request(2);
        while (!scl_oe) @(negedge clk);
        chk(cycle - t_req >= LIMIT && cycle - t_req <= LIMIT + 3,
            "R6 forced access after limit", cycle - t_req, LIMIT + 2);
        chk(status == 8'hF8 && !sda_oe, "R7 forced access runs recovery", int'(status), 248);
        ext_sda_low = 1'b0;
        wait_irq("R7 START after forced recovery");
        release_bus();

        chk(exp_q.size() == 0, "R4 all expected starts seen", exp_q.size(), 0);
        finish_run();
    end

endmodule